// File: doc/BRIEF.md
# Segment-Folded Virtual Address Expander

This block widens a narrow effective virtual address into a larger global virtual address. The top bits of the incoming address pick one entry of a small segment table. That entry holds a wide segment identifier. The output address is that identifier placed on top of the low offset bits, which pass through unchanged.

Software, or a neighbouring control block, loads the table through a one-entry-per-cycle write port. Two address spaces can share a segment by loading the same identifier into their tables. They keep a segment private by loading an identifier that nobody else uses. No per-entry process tag is compared anywhere.

The lookup is purely combinational. An address presented with its valid bit appears expanded in the same cycle. With the default sizes, a 64-bit address with a 12-bit segment index and a 52-bit offset becomes an 80-bit address carrying a 28-bit identifier.

Top module: `seg_fold_xlate`

## Requirements
- R1: The upper SID_W bits of `out_gva` equal the table entry selected by the segment index, which is bits [VA_W-1 : VA_W-IDX_W] of `in_va`.
- R2: The lower VA_W-IDX_W bits of `out_gva` equal the same bits of `in_va`, unchanged.
- R3: `out_valid` equals `in_valid` in the same cycle, with no register between them.
- R4: After reset, every table entry holds identifier zero, so any lookup returns zero in the upper bits.
- R5: A write with `wr_en` high changes the entry at `wr_idx` at the next rising clock edge. A lookup of that index in the same cycle as the write returns the previous identifier.
- R6: When `wr_en` is low, `wr_idx` and `wr_sid` have no effect on any table entry.
- R7: A write changes only the entry it addresses. Two indices loaded with the same identifier yield identical upper bits, and indices loaded with different identifiers stay distinct.
- R8: The output width is VA_W - IDX_W + SID_W, and elaboration stops with an error if IDX_W is not less than VA_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; table writes happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears the table |
| wr_en | input | 1 | Table write enable |
| wr_idx | input | IDX_W | Table entry to write |
| wr_sid | input | SID_W | Segment identifier to store |
| in_valid | input | 1 | Input address valid |
| in_va | input | VA_W | Narrow effective virtual address |
| out_valid | output | 1 | Expanded address valid |
| out_gva | output | VA_W-IDX_W+SID_W | Expanded global virtual address |

## Verification
The bench aims at the write/lookup collision on one index. A design that forwards the new identifier returns it one cycle early. A design that registers the read path returns a stale value after the write lands.

The bench also drives writes with the enable low. A table that ignores the enable picks up garbage, and this shows up in later lookups.

The extreme indices 0 and all-ones, together with all-ones and alternating offsets, expose a split point that is off by one bit. A corrupted offset, or an identifier shifted into the offset field, differs from the bench's independently computed expected address.

// File: rtl/seg_fold_pkg.sv
package seg_fold_pkg;

  // Width of the expanded address for a given split.
  function automatic int gva_width(input int va_w, input int idx_w, input int sid_w);
    return va_w - idx_w + sid_w;
  endfunction

  // Number of table entries addressed by an index of the given width.
  function automatic int table_depth(input int idx_w);
    return 1 << idx_w;
  endfunction

endpackage

// File: rtl/seg_idx_table.sv
module seg_idx_table #(
  parameter int IDX_W = 12,
  parameter int SID_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SID_W-1:0] wr_sid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SID_W-1:0] rd_sid
);
  localparam int DEPTH = seg_fold_pkg::table_depth(IDX_W);

  logic [SID_W-1:0] entry_q [DEPTH];

  // Synchronous reset clears all entries; writes land at the edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (wr_en) begin
      entry_q[wr_idx] <= wr_sid;
    end
  end

  // Read is combinational from stored state, so a same-cycle write is not seen.
  assign rd_sid = entry_q[rd_idx];

  // R4: the first cycle out of reset reads zero at whatever index is presented
  p_reset_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_sid == '0);

  // R5: a write is visible at the read port one edge later
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_idx == $past(wr_idx) && !$rose(rst_n)) |-> rd_sid == $past(wr_sid));

  // R6: an entry not written last cycle keeps its value
  p_hold_unwritten_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(rst_n) && rd_idx == $past(rd_idx) && !($past(wr_en) && $past(wr_idx) == rd_idx))
      |-> $stable(rd_sid));

endmodule

// File: rtl/seg_va_split.sv
module seg_va_split #(
  parameter int VA_W  = 64,
  parameter int IDX_W = 12,
  parameter int SID_W = 28
) (
  input  logic [VA_W-1:0]              va,
  input  logic [SID_W-1:0]             sid,
  output logic [IDX_W-1:0]             idx,
  output logic [VA_W-IDX_W+SID_W-1:0]  gva
);
  localparam int OFF_W = VA_W - IDX_W;
  localparam int GVA_W = seg_fold_pkg::gva_width(VA_W, IDX_W, SID_W);

  function automatic logic [IDX_W-1:0] seg_index(input logic [VA_W-1:0] a);
    return a[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] seg_offset(input logic [VA_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [GVA_W-1:0] join_gva(input logic [SID_W-1:0] s,
                                                input logic [OFF_W-1:0] o);
    return {s, o};
  endfunction

  assign idx = seg_index(va);
  assign gva = join_gva(sid, seg_offset(va));

endmodule

// File: rtl/seg_fold_xlate.sv
module seg_fold_xlate #(
  parameter int VA_W  = 64,
  parameter int IDX_W = 12,
  parameter int SID_W = 28
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [SID_W-1:0]             wr_sid,
  input  logic                         in_valid,
  input  logic [VA_W-1:0]              in_va,
  output logic                         out_valid,
  output logic [VA_W-IDX_W+SID_W-1:0]  out_gva
);
  localparam int OFF_W = VA_W - IDX_W;
  localparam int GVA_W = seg_fold_pkg::gva_width(VA_W, IDX_W, SID_W);

  // R8: elaboration guard on the split point
  if (IDX_W >= VA_W || IDX_W < 1 || SID_W < 1) begin : g_bad_split
    $error("seg_fold_xlate: segment index must be narrower than the address");
  end

  logic [IDX_W-1:0] lookup_idx;
  logic [SID_W-1:0] lookup_sid;

  seg_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .SID_W(SID_W)) u_split (
    .va  (in_va),
    .sid (lookup_sid),
    .idx (lookup_idx),
    .gva (out_gva)
  );

  seg_idx_table #(.IDX_W(IDX_W), .SID_W(SID_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_sid (wr_sid),
    .rd_idx (lookup_idx),
    .rd_sid (lookup_sid)
  );

  assign out_valid = in_valid;

  // R8: port width agrees with the derived width
  initial p_width_r8: assert (GVA_W == $bits(out_gva));

  // R1: upper field carries the identifier read from the table
  p_sid_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_gva[GVA_W-1 -: SID_W] == lookup_sid);

  // R2: offset field passes through untouched
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_gva[OFF_W-1:0] == in_va[OFF_W-1:0]);

  // R1: the index fed to the table comes from the top bits of the address
  p_index_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_idx == in_va[VA_W-1:OFF_W]);

endmodule

// File: tb/seg_fold_xlate_tb.sv
module seg_fold_xlate_tb;
  localparam int VA_W  = 64;
  localparam int IDX_W = 12;
  localparam int SID_W = 28;
  localparam int OFF_W = VA_W - IDX_W;
  localparam int GVA_W = OFF_W + SID_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [SID_W-1:0]  wr_sid = '0;
  logic              in_valid = 1'b0;
  logic [VA_W-1:0]   in_va = '0;
  logic              out_valid;
  logic [GVA_W-1:0]  out_gva;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [SID_W-1:0] model [int];

  seg_fold_xlate #(.VA_W(VA_W), .IDX_W(IDX_W), .SID_W(SID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sid(wr_sid),
    .in_valid(in_valid), .in_va(in_va), .out_valid(out_valid), .out_gva(out_gva)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [GVA_W-1:0] act, input logic [GVA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected address by arithmetic: identifier scaled past the offset, plus the masked offset.
  function automatic logic [GVA_W-1:0] expect_gva(input logic [VA_W-1:0] va);
    logic [GVA_W-1:0] s, o;
    int key;
    key = int'(va >> OFF_W);
    s = model.exists(key) ? GVA_W'(model[key]) : '0;
    o = GVA_W'(va) & ((GVA_W'(1) << OFF_W) - 1);
    return (s << OFF_W) + o;
  endfunction

  function automatic logic [VA_W-1:0] mk_va(input int idx, input logic [OFF_W-1:0] off);
    return (VA_W'(idx) << OFF_W) | VA_W'(off);
  endfunction

  task automatic do_write(input int idx, input logic [SID_W-1:0] sid);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_sid = sid;
    @(negedge clk);
    wr_en = 1'b0;
    model[idx] = sid;
  endtask

  task automatic look(input string req, input int idx, input logic [OFF_W-1:0] off);
    @(negedge clk);
    in_valid = 1'b1; in_va = mk_va(idx, off);
    #1 chk(req, out_gva, expect_gva(in_va));
  endtask

  task automatic t_reset;
    look("R4 reset idx0", 0, 52'h1234_5678_9ABC_D);
    chk("R4 zero upper", GVA_W'(out_gva >> OFF_W), '0);
    look("R4 reset idxmax", (1 << IDX_W) - 1, '1);
    look("R4 reset mid", 12'h5A5, 52'hA_AAAA_AAAA_AAAA);
  endtask

  task automatic t_basic;
    do_write(3, 28'hABC_DEF1);
    look("R1 basic idx3", 3, 52'h0_0000_0000_0001);
    look("R2 offset ones", 3, '1);
    do_write(0, 28'hFFF_FFFF);
    look("R1 idx0 allones sid", 0, 52'h5_5555_5555_5555);
    do_write((1 << IDX_W) - 1, 28'h000_0001);
    look("R1 idxmax", (1 << IDX_W) - 1, 52'hF_0F0F_0F0F_0F0F);
    look("R2 offset zero", (1 << IDX_W) - 1, '0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 12'h040; wr_sid = 28'h777_0000;
    in_valid = 1'b1; in_va = mk_va(12'h040, 52'h1);
    #1 chk("R5 same cycle old", out_gva, expect_gva(in_va));
    @(negedge clk);
    wr_en = 1'b0;
    model[12'h040] = 28'h777_0000;
    #1 chk("R5 next cycle new", out_gva, expect_gva(in_va));
    chk("R5 new sid value", GVA_W'(out_gva >> OFF_W), GVA_W'(28'h777_0000));
  endtask

  task automatic t_ignore;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 12'h003; wr_sid = 28'h0BA_D0BA;
    @(negedge clk);
    wr_idx = 12'h040; wr_sid = 28'h0BA_D0BB;
    @(negedge clk);
    look("R6 idx3 untouched", 3, 52'h2);
    look("R6 idx40 untouched", 12'h040, 52'h3);
  endtask

  task automatic t_share;
    do_write(12'h100, 28'h123_4567);
    do_write(12'h200, 28'h123_4567);
    do_write(12'h201, 28'h765_4321);
    look("R7 shared a", 12'h100, 52'h9);
    look("R7 shared b", 12'h200, 52'h9);
    chk("R7 shared equal upper", GVA_W'(out_gva >> OFF_W), GVA_W'(28'h123_4567));
    look("R7 private", 12'h201, 52'h9);
    look("R7 neighbour unchanged", 12'h1FF, 52'h9);
    look("R7 idx3 unchanged", 3, 52'h9);
  endtask

  task automatic t_valid;
    @(negedge clk);
    in_valid = 1'b0;
    #1 chk("R3 valid low", GVA_W'(out_valid), GVA_W'(1'b0));
    @(negedge clk);
    in_valid = 1'b1;
    #1 chk("R3 valid high", GVA_W'(out_valid), GVA_W'(1'b1));
    chk("R8 width", GVA_W'($bits(out_gva)), GVA_W'(VA_W - IDX_W + SID_W));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_same_cycle();
    t_ignore();
    t_share();
    t_valid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule